// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block drives a three-wire serial EEPROM that stores 16-bit words at 8-bit addresses. A host hands it one command at a time over a valid/ready handshake: read a word, program a word, unlock programming, or program every word with one value. The block then produces the chip select, the serial clock and the serial data toward the memory, and samples the memory's serial data output.

Every serial bit is put on the data line while the clock is low, and is followed by one full clock pulse. Each half of the pulse, and each setup phase, lasts a programmable number of system clocks. A read checks the leading zero that the memory sends before its data word, and aborts on a one. After a programming command the block closes the frame, opens a new one, and samples the memory's data output at a fixed interval until it reads high. It gives up after a fixed number of samples. The result is a one-cycle done pulse with the read word and an error flag.

Top module: `mw_eeprom_master`

## Requirements
- R1: `cmd_ready` is high only while no command is in progress. A command on `cmd_op` is accepted on a clock edge with `cmd_valid` and `cmd_ready` both high, and `cmd_ready` is low from the next cycle until the done pulse. The codes are 0 read, 1 program word, 2 unlock, 3 program all.
- R2: Every command first keeps `ser_cs` low for one half period and then raises it. `ser_clk` is high only while `ser_cs` is high, and `ser_cs` never rises while `ser_clk` is high.
- R3: Each bit is driven on `ser_dout` during a low setup phase. Then `ser_clk` is high for one phase and low for one phase. Each phase lasts HALF_DIV system clocks, and `ser_dout` does not change while `ser_clk` is high.
- R4: A read sends 1,1,0 and the 8 address bits MSB first. It then takes 17 input samples, each just before its clock pulse: a leading bit and 16 data bits MSB first. That is 28 pulses in all. The done pulse comes HALF_DIV*86 clocks after acceptance, with the word on `rsp_rdata` and `rsp_err` low.
- R5: If the leading bit of a read samples 1, no further pulse is issued and `rsp_err` is high at done. Done comes HALF_DIV*36 clocks after acceptance, after 11 pulses.
- R6: A program-word command sends 1,0,1, the 8 address bits and the 16 data bits, all MSB first, in 27 pulses.
- R7: An unlock command sends 1,0,0 then 1,1,0,0,0,0,0,0 in 11 pulses. It has no data phase and no polling, and its done pulse comes HALF_DIV*35 clocks after acceptance.
- R8: A program-all command sends 1,0,0, then 0,1,0,0,0,0,0,0, then the 16 data bits MSB first, in 27 pulses.
- R9: After a program-word or program-all frame, `ser_cs` goes low for one half period and rises again. `ser_din` is then sampled every POLL_GAP clocks, and the command completes without error at the first high sample.
- R10: If POLL_MAX consecutive samples are low, the command ends with `rsp_err` high.
- R11: `ser_cs` is low in the cycle after every done pulse, whether or not the command failed.
- R12: `rsp_done` lasts one cycle. `rsp_rdata` keeps the last word read successfully until another read succeeds. `rsp_err` stays until the next command is accepted and is low from the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 2 | Command code (0 read, 1 program, 2 unlock, 3 program all) |
| cmd_addr | input | 8 | Word address |
| cmd_wdata | input | 16 | Word to program |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Last word read |
| rsp_err | output | 1 | Failure flag of the last command |
| ser_cs | output | 1 | Memory chip select |
| ser_clk | output | 1 | Serial clock |
| ser_dout | output | 1 | Serial data toward the memory |
| ser_din | input | 1 | Serial data from the memory |

## Verification
The timing is fixed by the phase count, so the bench knows exactly when each result is due. After acceptance, a read's done pulse is due after HALF_DIV*86 clocks, an unlock's after HALF_DIV*35, and an aborted read's after HALF_DIV*36. The bench counts rising clock edges from the accepting edge and compares that count with these figures. It samples the result word and the error flag at the falling edge where done is first seen, and checks the chip select, ready and the hold of the outputs one cycle later. A memory model in the bench samples at falling edges, counts the clock pulses of each frame, and compares the count with the frame length due for the command.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int MW_ADDR_W = 8;
    localparam int MW_DATA_W = 16;
    localparam int MW_OPC_W  = 3;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_WEN   = 2'd2,
        OP_WRALL = 2'd3
    } mw_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CSLO,
        ST_CSHI,
        ST_SET,
        ST_HI,
        ST_LO,
        ST_DROP,
        ST_POLL,
        ST_FIN
    } mw_st_e;

    typedef enum logic {
        DIR_TX,
        DIR_RX
    } mw_dir_e;

    // state of the three serial wires toward the memory
    typedef struct packed {
        logic cs;
        logic sk;
        logic dout;
    } mw_pins_t;

    function automatic logic [MW_OPC_W-1:0] opcode_of(mw_op_e op);
        case (op)
            OP_READ:  return 3'b110;
            OP_WRITE: return 3'b101;
            default:  return 3'b100;
        endcase
    endfunction

endpackage

// File: rtl/mw_halfdiv.sv
module mw_halfdiv #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == LAST);

    generate
        if (HALF > 1) begin : g_spacing
            // phases are at least two clocks long, so ticks never touch
            p_tick_spacing_r3: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/mw_poll_ctr.sv
module mw_poll_ctr #(
    parameter int GAP = 16,
    parameter int MAX = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic strobe,
    output logic last
);
    localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;
    localparam int PW = $clog2(MAX + 1);
    localparam logic [GW-1:0] GLAST = GW'(GAP - 1);
    localparam logic [PW-1:0] PLAST = PW'(MAX - 1);

    logic [GW-1:0] gcnt;
    logic [PW-1:0] polls;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            gcnt  <= '0;
            polls <= '0;
        end else if (gcnt == GLAST) begin
            gcnt  <= '0;
            polls <= polls + 1'b1;
        end else begin
            gcnt <= gcnt + 1'b1;
        end
    end

    assign strobe = run && (gcnt == GLAST);
    assign last   = strobe && (polls == PLAST);

    // the sequencer must leave the polling state on the final sample
    p_timeout_exit_r10: assert property (@(posedge clk) disable iff (rst)
        last |=> !run);

endmodule

// File: rtl/mw_frame_build.sv
module mw_frame_build
    import mw_pkg::*;
#(
    parameter int AW = MW_ADDR_W,
    parameter int DW = MW_DATA_W,
    localparam int FW = MW_OPC_W + AW + DW,
    localparam int LW = $clog2(FW + 1)
) (
    input  mw_op_e          op,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [FW-1:0]   bits,
    output logic [LW-1:0]   tx_len,
    output logic            has_rx,
    output logic            poll
);
    localparam logic [AW-1:0] PAT_UNLOCK = {2'b11, {(AW-2){1'b0}}};
    localparam logic [AW-1:0] PAT_ALL    = {2'b01, {(AW-2){1'b0}}};
    localparam logic [LW-1:0] LEN_SHORT  = LW'(MW_OPC_W + AW);
    localparam logic [LW-1:0] LEN_LONG   = LW'(FW);

    logic [MW_OPC_W-1:0] opc;
    assign opc = opcode_of(op);

    always_comb begin
        bits   = '0;
        tx_len = LEN_SHORT;
        has_rx = 1'b0;
        poll   = 1'b0;
        case (op)
            OP_READ: begin
                bits   = {opc, addr, {DW{1'b0}}};
                has_rx = 1'b1;
            end
            OP_WRITE: begin
                bits   = {opc, addr, wdata};
                tx_len = LEN_LONG;
                poll   = 1'b1;
            end
            OP_WEN: begin
                bits   = {opc, PAT_UNLOCK, {DW{1'b0}}};
            end
            default: begin
                bits   = {opc, PAT_ALL, wdata};
                tx_len = LEN_LONG;
                poll   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master
    import mw_pkg::*;
#(
    parameter int ADDR_W   = MW_ADDR_W,
    parameter int DATA_W   = MW_DATA_W,
    parameter int HALF_DIV = 4,
    parameter int POLL_GAP = 16,
    parameter int POLL_MAX = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              ser_cs,
    output logic              ser_clk,
    output logic              ser_dout,
    input  logic              ser_din
);
    localparam int FW = MW_OPC_W + ADDR_W + DATA_W;
    localparam int LW = $clog2(FW + 1);
    localparam logic [LW-1:0] RX_LEN = LW'(DATA_W + 1);

    mw_st_e            st;
    mw_dir_e           dir;
    mw_pins_t          pins;
    logic [FW-1:0]     txsr;
    logic [DATA_W-1:0] rxsr;
    logic [DATA_W-1:0] rdata_q;
    logic [LW-1:0]     left;
    logic              has_rx_q, poll_q, first, err_q;

    logic [FW-1:0]     f_bits;
    logic [LW-1:0]     f_len;
    logic              f_rx, f_poll;
    logic              tick, p_strobe, p_last;

    mw_frame_build #(.AW(ADDR_W), .DW(DATA_W)) u_frame (
        .op     (mw_op_e'(cmd_op)),
        .addr   (cmd_addr),
        .wdata  (cmd_wdata),
        .bits   (f_bits),
        .tx_len (f_len),
        .has_rx (f_rx),
        .poll   (f_poll)
    );

    mw_halfdiv #(.HALF(HALF_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .en   (st != ST_IDLE),
        .tick (tick)
    );

    mw_poll_ctr #(.GAP(POLL_GAP), .MAX(POLL_MAX)) u_poll (
        .clk    (clk),
        .rst    (rst),
        .run    (st == ST_POLL),
        .strobe (p_strobe),
        .last   (p_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            dir      <= DIR_TX;
            pins     <= '0;
            txsr     <= '0;
            rxsr     <= '0;
            rdata_q  <= '0;
            left     <= '0;
            has_rx_q <= 1'b0;
            poll_q   <= 1'b0;
            first    <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (cmd_valid) begin
                    txsr     <= f_bits;
                    left     <= f_len;
                    has_rx_q <= f_rx;
                    poll_q   <= f_poll;
                    dir      <= DIR_TX;
                    err_q    <= 1'b0;
                    pins     <= '0;
                    st       <= ST_CSLO;
                end
                ST_CSLO: if (tick) begin
                    pins.cs <= 1'b1;
                    st      <= ST_CSHI;
                end
                ST_CSHI: if (tick) begin
                    pins.dout <= txsr[FW-1];
                    st        <= ST_SET;
                end
                ST_SET: if (tick) begin
                    if (dir == DIR_RX && first && ser_din) begin
                        err_q <= 1'b1;
                        pins  <= '0;
                        st    <= ST_FIN;
                    end else begin
                        if (dir == DIR_RX) begin
                            if (!first)
                                rxsr <= {rxsr[DATA_W-2:0], ser_din};
                            first <= 1'b0;
                        end
                        pins.sk <= 1'b1;
                        st      <= ST_HI;
                    end
                end
                ST_HI: if (tick) begin
                    pins.sk <= 1'b0;
                    st      <= ST_LO;
                end
                ST_LO: if (tick) begin
                    if (left > LW'(1)) begin
                        left <= left - 1'b1;
                        if (dir == DIR_TX) begin
                            txsr      <= txsr << 1;
                            pins.dout <= txsr[FW-2];
                        end
                        st <= ST_SET;
                    end else if (dir == DIR_RX) begin
                        rdata_q <= rxsr;
                        pins    <= '0;
                        st      <= ST_FIN;
                    end else if (has_rx_q) begin
                        dir       <= DIR_RX;
                        left      <= RX_LEN;
                        first     <= 1'b1;
                        pins.dout <= 1'b0;
                        st        <= ST_SET;
                    end else if (poll_q) begin
                        pins <= '0;
                        st   <= ST_DROP;
                    end else begin
                        pins <= '0;
                        st   <= ST_FIN;
                    end
                end
                ST_DROP: if (tick) begin
                    pins.cs <= 1'b1;
                    st      <= ST_POLL;
                end
                ST_POLL: if (p_strobe) begin
                    if (ser_din) begin
                        pins <= '0;
                        st   <= ST_FIN;
                    end else if (p_last) begin
                        err_q <= 1'b1;
                        pins  <= '0;
                        st    <= ST_FIN;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign cmd_ready = (st == ST_IDLE);
    assign rsp_done  = (st == ST_FIN);
    assign rsp_rdata = rdata_q;
    assign rsp_err   = err_q;
    assign ser_cs    = pins.cs;
    assign ser_clk   = pins.sk;
    assign ser_dout  = pins.dout;

    p_accept_busy_r1: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    p_clk_inside_cs_r2: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> ser_cs);

    p_cs_rise_clk_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_cs) |-> !ser_clk);

    p_dout_steady_r3: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_dout));

    p_setup_before_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_clk) |-> $stable(ser_dout));

    p_cs_low_after_done_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> (!ser_cs && cmd_ready));

    p_done_single_r12: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (cmd_ready && !cmd_valid) |=> $stable(rsp_rdata));

endmodule

// File: tb/test_mw_eeprom_master.sv
`timescale 1ns/1ps
module test_mw_eeprom_master;

    localparam int HALF = 4;
    localparam int GAP  = 16;
    localparam int PMAX = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'd0;
    logic [7:0]  cmd_addr = 8'd0;
    logic [15:0] cmd_wdata = 16'd0;
    logic        rsp_done, rsp_err;
    logic [15:0] rsp_rdata;
    logic        ser_cs, ser_clk, ser_dout;
    logic        ser_din;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mw_eeprom_master #(
        .ADDR_W(8), .DATA_W(16), .HALF_DIV(HALF), .POLL_GAP(GAP), .POLL_MAX(PMAX)
    ) i_mw_eeprom_master (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .ser_cs(ser_cs), .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_din(ser_din)
    );

    // ---------------- memory model, evaluated at falling edges ----------------
    logic [15:0] mem [256];
    bit          unlocked = 1'b0;
    bit          reading = 1'b0;
    bit          force_one = 1'b0;
    int          busy_len = 40;
    int          busy = 0;
    int          k = 0;
    int          pulses = 0;
    int          viol_r2 = 0;
    int          viol_r3 = 0;
    logic [26:0] shin = '0;
    logic [7:0]  rd_addr = '0;
    logic        rd_bit = 1'b0;
    bit          pend_w = 1'b0, pend_all = 1'b0;
    logic [7:0]  pend_a = '0;
    logic [15:0] pend_d = '0;
    logic        pcs = 1'b0, psk = 1'b0, pdo = 1'b0;

    initial for (int i = 0; i < 256; i++) mem[i] = {i[7:0], ~i[7:0]};

    always @(negedge clk) begin
        if (busy > busy_len) busy = busy_len;
        if (busy > 0) busy = busy - 1;
        if (ser_cs && !pcs) begin
            k = 0;
            shin = '0;
        end
        if (!ser_cs && pcs) begin
            reading = 1'b0;
            if (pend_w) begin
                mem[pend_a] = pend_d;
                busy = busy_len;
            end
            if (pend_all) begin
                for (int i = 0; i < 256; i++) mem[i] = pend_d;
                busy = busy_len;
            end
            pend_w = 1'b0;
            pend_all = 1'b0;
        end
        if (ser_clk && !ser_cs) viol_r2++;
        if (ser_clk && psk && ser_dout != pdo) viol_r3++;
        if (ser_clk && !psk) begin
            k++;
            pulses++;
            shin = {shin[25:0], ser_dout};
            if (k == 11) begin
                if (shin[10:8] == 3'b110) begin
                    reading = 1'b1;
                    rd_addr = shin[7:0];
                    rd_bit  = force_one;
                end
                if (shin[10:8] == 3'b100 && shin[7:0] == 8'hC0) unlocked = 1'b1;
            end
            if (reading && k >= 12 && k <= 27) rd_bit = mem[rd_addr][27-k];
            if (k == 27 && unlocked) begin
                if (shin[26:24] == 3'b101) begin
                    pend_w = 1'b1;
                    pend_a = shin[23:16];
                    pend_d = shin[15:0];
                end
                if (shin[26:24] == 3'b100 && shin[23:16] == 8'h40) begin
                    pend_all = 1'b1;
                    pend_d = shin[15:0];
                end
            end
        end
        pcs = ser_cs;
        psk = ser_clk;
        pdo = ser_dout;
        ser_din = reading ? rd_bit : (busy == 0);
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [7:0] a, input logic [15:0] wd,
                           output logic [15:0] rd, output logic er, output int lat, output int np);
        int p0;
        @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_wdata = wd; cmd_valid = 1'b1;
        p0 = pulses;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R1 ready low after accept", {31'd0, cmd_ready}, 32'd0);
        chk("R12 error cleared after accept", {31'd0, rsp_err}, 32'd0);
        lat = 0;
        while (!rsp_done && lat < 50000) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        if (lat >= 50000) chk("R1 command never completed", 32'd0, 32'd1);
        rd = rsp_rdata;
        er = rsp_err;
        np = pulses - p0;
        @(negedge clk);
        chk("R11 cs low after done", {31'd0, ser_cs}, 32'd0);
        chk("R1 ready back after done", {31'd0, cmd_ready}, 32'd1);
        chk("R12 done lasts one cycle", {31'd0, rsp_done}, 32'd0);
        chk("R12 read word held after done", {16'd0, rsp_rdata}, {16'd0, rd});
    endtask

    // op, addr, wdata, expected read word, expected error, expected pulse count
    localparam logic [50:0] VEC [8] = '{
        {2'd2, 8'h00, 16'h0000, 16'h0000, 1'b0, 8'd11},
        {2'd1, 8'hA5, 16'h1234, 16'h0000, 1'b0, 8'd27},
        {2'd0, 8'hA5, 16'h0000, 16'h1234, 1'b0, 8'd28},
        {2'd0, 8'h3C, 16'h0000, 16'h3CC3, 1'b0, 8'd28},
        {2'd1, 8'h00, 16'hFFFF, 16'h0000, 1'b0, 8'd27},
        {2'd0, 8'h00, 16'h0000, 16'hFFFF, 1'b0, 8'd28},
        {2'd3, 8'h00, 16'hBEEF, 16'h0000, 1'b0, 8'd27},
        {2'd0, 8'h81, 16'h0000, 16'hBEEF, 1'b0, 8'd28}
    };

    initial begin
        logic [15:0] rd;
        logic        er;
        int          lat, np;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", {31'd0, cmd_ready}, 32'd1);
        chk("R2 cs low after reset", {31'd0, ser_cs}, 32'd0);
        chk("R2 clock low after reset", {31'd0, ser_clk}, 32'd0);
        chk("R12 no done after reset", {31'd0, rsp_done}, 32'd0);
        chk("R12 error low after reset", {31'd0, rsp_err}, 32'd0);

        for (int v = 0; v < 8; v++) begin
            logic [1:0] op;
            op = VEC[v][50:49];
            run_cmd(op, VEC[v][48:41], VEC[v][40:25], rd, er, lat, np);
            chk("R9 error flag of table command", {31'd0, er}, {31'd0, VEC[v][8]});
            case (op)
                2'd0: begin
                    chk("R4 read word", {16'd0, rd}, {16'd0, VEC[v][24:9]});
                    chk("R4 read pulse count", np, {24'd0, VEC[v][7:0]});
                    chk("R4 read latency", lat, HALF * 86);
                end
                2'd1: chk("R6 program pulse count", np, {24'd0, VEC[v][7:0]});
                2'd2: begin
                    chk("R7 unlock pulse count", np, {24'd0, VEC[v][7:0]});
                    chk("R7 unlock latency", lat, HALF * 35);
                end
                default: chk("R8 program-all pulse count", np, {24'd0, VEC[v][7:0]});
            endcase
        end

        // R5: leading bit reads as one
        force_one = 1'b1;
        run_cmd(2'd0, 8'h20, 16'h0, rd, er, lat, np);
        force_one = 1'b0;
        chk("R5 error on bad leading bit", {31'd0, er}, 32'd1);
        chk("R5 pulses stop after leading bit", np, 11);
        chk("R5 abort latency", lat, HALF * 36);
        chk("R12 read word kept after failed read", {16'd0, rd}, 32'h0000BEEF);

        // R12: error cleared by next command (checked inside run_cmd), result good
        run_cmd(2'd0, 8'h20, 16'h0, rd, er, lat, np);
        chk("R12 error low after good read", {31'd0, er}, 32'd0);
        chk("R8 program-all reached address 20", {16'd0, rd}, 32'h0000BEEF);

        // R10: memory never signals ready
        busy_len = 100000;
        run_cmd(2'd1, 8'h11, 16'h5A5A, rd, er, lat, np);
        chk("R10 timeout raises error", {31'd0, er}, 32'd1);
        chk("R10 poll window length", {31'd0, lat >= PMAX * GAP}, 32'd1);
        busy_len = 30;
        repeat (40) @(negedge clk);

        // R9: ready after a few polls, word lands
        run_cmd(2'd1, 8'h77, 16'hC0DE, rd, er, lat, np);
        chk("R9 poll success no error", {31'd0, er}, 32'd0);
        run_cmd(2'd0, 8'h77, 16'h0, rd, er, lat, np);
        chk("R6 programmed word reads back", {16'd0, rd}, 32'h0000C0DE);

        chk("R2 no clock pulse outside chip select", viol_r2, 0);
        chk("R3 data steady while clock high", viol_r3, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog expired: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule